// File: doc/BRIEF.md
# Microsequenced Fetch-Execute Control Unit

This block is the sequencer of a small accumulator machine. It does not store datapath values. Each clock it drives the control lines that the register bank, the memory and the ALU act on:
- a source-select code for the shared data bus,
- a destination-select code,
- a memory read strobe and a memory write strobe,
- an ALU operation code.

A one-hot step vector marks the current register-transfer step. It moves forward by one position per clock.

Every instruction starts with the same three fetch steps. In the first, the program counter goes to the address register. In the second, memory is read into the instruction register. In the third, the ALU increments the program counter. From the fourth step on, the block reads the 4-bit opcode from the top of the instruction register through its decode input. It then plays that instruction's execute steps. After the last one, the step vector returns to its first position. Skip instructions also take two condition bits, which are bits 11:10 of the instruction register. A halt instruction parks the sequencer until reset.

All control outputs are a combinational function of the step register, the opcode and the condition bits. A parameter selects whether the step register is kept one-hot or as a binary count decoded to one-hot.

Top module: `fe_ctl_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, the step output is 6'b000001 (T0), and the outputs perform the first fetch transfer.
- R2: Fetch occupies steps T0 to T2 of every instruction:
  - T0: source 010 (PC), destination 001 (MAR).
  - T1: source 000, memory read 1, destination 111 (IR).
  - T2: selects 000, ALU op 111 (increment PC).
- R3: Exactly one bit of the step output is high in every cycle. Bit n means n transfers of the current instruction are already done. Outside halt and end-of-instruction, the high bit moves up by one each clock.
- R4: Load (opcode 1) executes three steps:
  - T3: source 111, destination 001.
  - T4: memory read, destination 011.
  - T5: source 011, destination 100.
- R5: Add (opcode 3) and Subtract (opcode 4) execute the same T3 and T4 as Load. At T5 both selects are 000, and the ALU op is 001 for Add or 010 for Subtract.
- R6: Skip-conditional (opcode 8) executes one step, T3. Its ALU op follows the condition bits: 00 gives 100, 01 gives 101, 10 gives 110, and 11 gives 000.
- R7: Jump (opcode 9) executes one step, T3: source 111, destination 010.
- R8: Halt (opcode 7) holds the step output at T3 with all selects, strobes and ALU op at 0 until reset is asserted.
- R9: Any other opcode, including 0, 2 and 15, executes a single idle step at T3 with all control outputs 0.
- R10: In the clock after an instruction's last execute step, the step output returns to T0 and a new fetch begins.
- R11: The memory read strobe is high only when the source select is 000. The memory write strobe stays 0 for every instruction in this set.

Codes used throughout: select 000=memory/none, 001=MAR, 010=PC, 011=MBR, 100=AC, 101=IN, 110=OUT, 111=IR. ALU 000=none, 001=add, 010=subtract, 011=clear, 100/101/110=skip if AC negative/zero/positive, 111=increment PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_op | input | 4 | Opcode from the top four bits of the instruction register |
| skip_cond | input | 2 | Instruction register bits 11:10, used by skip-conditional |
| rd_sel | output | 3 | Data-bus source select |
| wr_sel | output | 3 | Data-bus destination select |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| alu_op | output | 3 | ALU operation code |
| step | output | NUM_STEPS (6) | One-hot step vector, bit n is Tn |

## Verification
The bench plays back-to-back instructions of different lengths: three-step loads and arithmetic, one-step jumps, skips and unknown opcodes. A counter that misses its wrap then shows up as a T4 or a lost step where the next T0 should be. Every skip condition is covered, including the unused code 11. A wrong mapping there gives the wrong ALU op, or a stray skip where none should happen. Halt is held for several cycles to catch a sequencer that keeps moving or leaves a strobe on. Reset is then applied from the halted state to show that only reset recovers it.

// File: rtl/fe_pkg.sv
package fe_pkg;

   typedef enum logic [2:0] {
      SEL_MEM = 3'd0,
      SEL_MAR = 3'd1,
      SEL_PC  = 3'd2,
      SEL_MBR = 3'd3,
      SEL_AC  = 3'd4,
      SEL_IN  = 3'd5,
      SEL_OUT = 3'd6,
      SEL_IR  = 3'd7
   } sel_e;

   typedef enum logic [2:0] {
      ALU_NONE  = 3'd0,
      ALU_ADD   = 3'd1,
      ALU_SUB   = 3'd2,
      ALU_CLR   = 3'd3,
      ALU_SKNEG = 3'd4,
      ALU_SKZER = 3'd5,
      ALU_SKPOS = 3'd6,
      ALU_INCPC = 3'd7
   } alu_e;

   localparam int OPC_W  = 4;
   localparam int COND_W = 2;

   localparam logic [OPC_W-1:0] OPC_LOAD = 4'd1;
   localparam logic [OPC_W-1:0] OPC_ADD  = 4'd3;
   localparam logic [OPC_W-1:0] OPC_SUB  = 4'd4;
   localparam logic [OPC_W-1:0] OPC_HALT = 4'd7;
   localparam logic [OPC_W-1:0] OPC_SKIP = 4'd8;
   localparam logic [OPC_W-1:0] OPC_JUMP = 4'd9;

   // Last step index used by the longest execute sequence
   localparam int LAST_USED_STEP = 5;

endpackage

// File: rtl/fe_step_ctr.sv
module fe_step_ctr #(
   parameter int NUM_STEPS = 6,
   parameter bit ONE_HOT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 last,
   input  logic                 hold,
   output logic [NUM_STEPS-1:0] step_oh
);

   localparam int CNT_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;

   generate
      if (NUM_STEPS < fe_pkg::LAST_USED_STEP + 1) begin : g_bad_depth
         $error("fe_step_ctr: NUM_STEPS too small for the longest instruction");
      end

      if (ONE_HOT) begin : g_onehot
         logic [NUM_STEPS-1:0] oh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       oh_q <= NUM_STEPS'(1);
            else if (hold)    oh_q <= oh_q;
            else if (last)    oh_q <= NUM_STEPS'(1);
            else              oh_q <= {oh_q[NUM_STEPS-2:0], 1'b0};
         end
         assign step_oh = oh_q;
      end else begin : g_binary
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (hold)    cnt_q <= cnt_q;
            else if (last)    cnt_q <= '0;
            else              cnt_q <= cnt_q + CNT_W'(1);
         end
         assign step_oh = NUM_STEPS'(1) << cnt_q;
      end
   endgenerate

   p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(step_oh) == 1);

   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !hold) |=> step_oh[0]);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(step_oh));

endmodule

// File: rtl/fe_ucode.sv
module fe_ucode
   import fe_pkg::*;
#(
   parameter int NUM_STEPS = 6
) (
   input  logic [NUM_STEPS-1:0] step_oh,
   input  logic [OPC_W-1:0]     opc,
   input  logic [COND_W-1:0]    cond,
   output sel_e                 rd_sel,
   output sel_e                 wr_sel,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output alu_e                 alu_op,
   output logic                 last,
   output logic                 hold
);

   // Shared execute body of Load, Add and Subtract
   logic is_mem_op;
   assign is_mem_op = (opc == OPC_LOAD) || (opc == OPC_ADD) || (opc == OPC_SUB);

   always_comb begin
      rd_sel = SEL_MEM;
      wr_sel = SEL_MEM;
      mem_rd = 1'b0;
      mem_wr = 1'b0;
      alu_op = ALU_NONE;
      last   = 1'b0;
      hold   = 1'b0;
      if (step_oh[0]) begin
         rd_sel = SEL_PC;
         wr_sel = SEL_MAR;
      end else if (step_oh[1]) begin
         mem_rd = 1'b1;
         wr_sel = SEL_IR;
      end else if (step_oh[2]) begin
         alu_op = ALU_INCPC;
      end else if (is_mem_op) begin
         if (step_oh[3]) begin
            rd_sel = SEL_IR;
            wr_sel = SEL_MAR;
         end else if (step_oh[4]) begin
            mem_rd = 1'b1;
            wr_sel = SEL_MBR;
         end else if (step_oh[5]) begin
            last = 1'b1;
            if (opc == OPC_LOAD) begin
               rd_sel = SEL_MBR;
               wr_sel = SEL_AC;
            end else if (opc == OPC_ADD) begin
               alu_op = ALU_ADD;
            end else begin
               alu_op = ALU_SUB;
            end
         end else begin
            last = 1'b1;
         end
      end else if (opc == OPC_HALT) begin
         hold = 1'b1;
      end else if (opc == OPC_SKIP) begin
         last = 1'b1;
         case (cond)
            2'b00:   alu_op = ALU_SKNEG;
            2'b01:   alu_op = ALU_SKZER;
            2'b10:   alu_op = ALU_SKPOS;
            default: alu_op = ALU_NONE;
         endcase
      end else if (opc == OPC_JUMP) begin
         last   = 1'b1;
         rd_sel = SEL_IR;
         wr_sel = SEL_PC;
      end else begin
         last = 1'b1;
      end
   end

endmodule

// File: rtl/fe_ctl_top.sv
module fe_ctl_top
   import fe_pkg::*;
#(
   parameter int NUM_STEPS = 6,
   parameter bit ONE_HOT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [3:0]           dec_op,
   input  logic [1:0]           skip_cond,
   output logic [2:0]           rd_sel,
   output logic [2:0]           wr_sel,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic [2:0]           alu_op,
   output logic [NUM_STEPS-1:0] step
);

   logic [NUM_STEPS-1:0] step_oh;
   logic                 last;
   logic                 hold;
   sel_e                 rd_e;
   sel_e                 wr_e;
   alu_e                 alu_e_w;

   fe_step_ctr #(
      .NUM_STEPS (NUM_STEPS),
      .ONE_HOT   (ONE_HOT)
   ) step_ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .last    (last),
      .hold    (hold),
      .step_oh (step_oh)
   );

   fe_ucode #(
      .NUM_STEPS (NUM_STEPS)
   ) ucode_i (
      .step_oh (step_oh),
      .opc     (dec_op),
      .cond    (skip_cond),
      .rd_sel  (rd_e),
      .wr_sel  (wr_e),
      .mem_rd  (mem_rd),
      .mem_wr  (mem_wr),
      .alu_op  (alu_e_w),
      .last    (last),
      .hold    (hold)
   );

   assign rd_sel = rd_e;
   assign wr_sel = wr_e;
   assign alu_op = alu_e_w;
   assign step   = step_oh;

   p_fetch_t0_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step[0] |=> step[1]);

   p_fetch_t1_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step[1] |=> step[2]);

   p_mem_rd_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (rd_sel == 3'd0));

   p_no_mem_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr);

   p_jump_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step[3] && dec_op == OPC_JUMP) |=> step[0]);

   p_halt_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step[3] && dec_op == OPC_HALT && $stable(dec_op)) |=> step[3]);

endmodule

// File: tb/fe_ctl_top_tb_top.sv
`timescale 1ns/1ps
module fe_ctl_top_tb_top;

   localparam int NS = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    dec_op = 4'd0;
   logic [1:0]    skip_cond = 2'd0;
   logic [2:0]    rd_sel, wr_sel, alu_op;
   logic          mem_rd, mem_wr;
   logic [NS-1:0] step;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   fe_ctl_top #(.NUM_STEPS(NS)) dut_i (
      .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .skip_cond(skip_cond),
      .rd_sel(rd_sel), .wr_sel(wr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .alu_op(alu_op), .step(step)
   );

   typedef struct {
      logic [2:0] rd;
      logic [2:0] wr;
      logic       mrd;
      logic [2:0] alu;
      int         idx;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   task automatic push_exp(input logic [2:0] rd, input logic [2:0] wr,
                           input logic mrd, input logic [2:0] alu,
                           input int idx, input string tag);
      exp_t e;
      e.rd = rd; e.wr = wr; e.mrd = mrd; e.alu = alu; e.idx = idx; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic push_fetch(input string t0_tag);
      push_exp(3'd2, 3'd1, 1'b0, 3'd0, 0, t0_tag);
      push_exp(3'd0, 3'd7, 1'b1, 3'd0, 1, "R2");
      push_exp(3'd0, 3'd0, 1'b0, 3'd7, 2, "R2");
   endtask

   // Drives one instruction and queues its expected per-step outputs
   task automatic run_instr(input logic [3:0] op, input logic [1:0] cnd,
                            input string t0_tag);
      int len;
      dec_op    = op;
      skip_cond = cnd;
      push_fetch(t0_tag);
      if (op == 4'd1 || op == 4'd3 || op == 4'd4) begin
         push_exp(3'd7, 3'd1, 1'b0, 3'd0, 3, (op == 4'd1) ? "R4" : "R5");
         push_exp(3'd0, 3'd3, 1'b1, 3'd0, 4, (op == 4'd1) ? "R4" : "R5");
         if (op == 4'd1)      push_exp(3'd3, 3'd4, 1'b0, 3'd0, 5, "R4");
         else if (op == 4'd3) push_exp(3'd0, 3'd0, 1'b0, 3'd1, 5, "R5");
         else                 push_exp(3'd0, 3'd0, 1'b0, 3'd2, 5, "R5");
         len = 6;
      end else if (op == 4'd8) begin
         push_exp(3'd0, 3'd0, 1'b0,
                  (cnd == 2'd3) ? 3'd0 : 3'(3'd4 + 3'(cnd)), 3, "R6");
         len = 4;
      end else if (op == 4'd9) begin
         push_exp(3'd7, 3'd2, 1'b0, 3'd0, 3, "R7");
         len = 4;
      end else begin
         push_exp(3'd0, 3'd0, 1'b0, 3'd0, 3, "R9");
         len = 4;
      end
      repeat (len) @(posedge clk);
      #1;
   endtask

   // Monitor: compares outputs at each falling edge against the queue head
   always @(negedge clk) begin
      exp_t e;
      logic [NS-1:0] es;
      if (sb_q.size() > 0) begin
         e  = sb_q.pop_front();
         es = NS'(1) << e.idx;
         n_checks++;
         if ({rd_sel, wr_sel, mem_rd, mem_wr, alu_op, step} !==
             {e.rd, e.wr, e.mrd, 1'b0, e.alu, es}) begin
            n_fail++;
            $display("FAIL %s (R3 step): got rd=%h wr=%h mrd=%b mwr=%b alu=%h step=%b, expected rd=%h wr=%h mrd=%b mwr=0 alu=%h step=%b",
                     e.tag, rd_sel, wr_sel, mem_rd, mem_wr, alu_op, step,
                     e.rd, e.wr, e.mrd, e.alu, es);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      push_exp(3'd2, 3'd1, 1'b0, 3'd0, 0, "R1");   // R1 check during reset
      @(posedge clk); #1;
      rst_n = 1'b1;
      run_instr(4'd1, 2'd0, "R1");    // first T0 after release
      run_instr(4'd3, 2'd0, "R10");
      run_instr(4'd4, 2'd0, "R10");
      run_instr(4'd8, 2'd0, "R10");
      run_instr(4'd8, 2'd1, "R10");
      run_instr(4'd8, 2'd2, "R10");
      run_instr(4'd8, 2'd3, "R10");
      run_instr(4'd9, 2'd0, "R10");
      run_instr(4'd0, 2'd0, "R10");
      run_instr(4'd2, 2'd0, "R10");
      run_instr(4'd15, 2'd3, "R10");
      run_instr(4'd1, 2'd0, "R10");
      // R8: halt parks at T3
      dec_op = 4'd7;
      push_fetch("R10");
      for (int i = 0; i < 6; i++) push_exp(3'd0, 3'd0, 1'b0, 3'd0, 3, "R8");
      repeat (9) @(posedge clk);
      #1;
      rst_n = 1'b0;
      push_exp(3'd2, 3'd1, 1'b0, 3'd0, 0, "R1");
      @(posedge clk); #1;
      rst_n = 1'b1;
      run_instr(4'd9, 2'd0, "R1");
      run_instr(4'd3, 2'd0, "R10");
      wait (sb_q.size() == 0);
      @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got no completion, expected end within 200000 cycles");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule